// File: doc/BRIEF.md
# Real-Time Clock Calendar

This block keeps wall-clock time and calendar date in binary: second, minute, hour, day of month, month and a two-digit year. A 1024 Hz tick enable drives it. An internal prescaler counts 1024 ticks to make each one-second advance. Each field carries into the next when it wraps. The day field wraps at the length of the current month, and February gets a 29th day in years divisible by four.

A century register sits beside the year. Only a register write changes it, so the year wrapping from 99 to 00 leaves it alone. A periodic interrupt can be enabled to fire on every tick. Each firing sets a sticky status flag that software clears by reading the status register. All fields can be read and written through a simple register port that has a combinational read path and single-cycle writes.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the fields read second 0, minute 0, hour 0, day 1, month 1, year 0 and century 19, with interrupt enable 0 and the irq output low.
- R2: The second field advances by exactly one on the 1024th tick after the prescaler last restarted, and not on the 1023rd.
- R3: Second and minute wrap from 59 to 0 and carry one into the next field; hour wraps from 23 to 0 and carries into the day.
- R4: The day wraps to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12, carrying into the month.
- R5: In month 2 the day wraps after 29 when year modulo 4 is 0, and after 28 otherwise.
- R6: Month wraps from 12 to 1 and carries into the year; year wraps from 99 to 0.
- R7: The century field (address 6) changes only on a write to it; a year wrap leaves it unchanged.
- R8: A write with address 0 to 5 (second, minute, hour, day, month, year) is visible on a read in the next cycle. A write to address 0 also restarts the prescaler.
- R9: Address 7 bit 0 is the periodic enable. While it is set, every tick sets the flag. While it is clear, ticks do not set the flag. irq is flag AND enable.
- R10: A read of address 7 returns the enable in bit 0 and the flag in bit 1, and clears the flag. If a tick with the enable set arrives in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 1024 Hz tick enable, one clock wide per tick |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effect on status) |
| addr | input | 3 | Register address: 0 second … 5 year, 6 century, 7 control/status |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| irq | output | 1 | Periodic interrupt request |

## Verification
The range assertions assume that software writes only legal values: second and minute below 60, hour below 24, day from 1 to the length of the month, and month from 1 to 12. Out-of-range writes are still stored, and the counters recover at the next wrap. The stimulus writes only legal calendar values. It drives tick and the register strobes at least one step after a rising edge, and it never writes and reads in the same cycle.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int NUM_FIELDS = 7;

  localparam logic [ADDR_W-1:0] ADR_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_HOUR = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_DAY  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_MON  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_YEAR = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_CENT = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd7;

  typedef struct packed {
    logic [DATA_W-1:0] century;
    logic [DATA_W-1:0] year;
    logic [3:0]        month;
    logic [4:0]        day;
    logic [4:0]        hour;
    logic [5:0]        minute;
    logic [5:0]        second;
  } calTime_t;

  typedef struct packed {
    logic                  secStep;
    logic [NUM_FIELDS-1:0] wrField;
    logic [DATA_W-1:0]     wrData;
  } calStrobe_t;
endpackage

// File: rtl/rtc_ctrl.sv
`timescale 1ns/1ps
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output calStrobe_t        strb,
  output logic              irqEn,
  output logic              flag
);
  localparam int PRE_W = $clog2(TICKS_PER_SEC);
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(TICKS_PER_SEC - 1);

  logic [PRE_W-1:0] preCnt;
  logic [NUM_FIELDS-1:0] fieldHit;
  logic statWr;
  logic statRd;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_dec
    assign fieldHit[g] = wrEn && (addr == ADDR_W'(g));
  end

  assign statWr = wrEn && (addr == ADR_STAT);
  assign statRd = rdEn && (addr == ADR_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (fieldHit[ADR_SEC]) begin
      preCnt <= '0;
    end else if (tick) begin
      preCnt <= (preCnt == PRE_MAX) ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn <= 1'b0;
    end else if (statWr) begin
      irqEn <= wrData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag <= 1'b0;
    end else if (tick && irqEn) begin
      flag <= 1'b1;
    end else if (statRd) begin
      flag <= 1'b0;
    end
  end

  always_comb begin
    strb.secStep = tick && (preCnt == PRE_MAX) && !fieldHit[ADR_SEC];
    strb.wrField = fieldHit;
    strb.wrData  = wrData;
  end
endmodule

// File: rtl/rtc_datapath.sv
`timescale 1ns/1ps
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int RESET_CENTURY = 19
) (
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t strb,
  output calTime_t   calNow
);
  localparam logic [DATA_W-1:0] CENT_INIT = DATA_W'(RESET_CENTURY);

  function automatic logic [4:0] monthLen(input logic [3:0] m, input logic [DATA_W-1:0] y);
    case (m)
      4'd2:                     monthLen = (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  monthLen = 5'd30;
      default:                  monthLen = 5'd31;
    endcase
  endfunction

  logic secWrap, minStep, minWrap, hourStep, hourWrap;
  logic dayStep, dayWrap, monStep, monWrap, yearStep, yearWrap;
  logic [4:0] dim;

  always_comb begin
    dim      = monthLen(calNow.month, calNow.year);
    secWrap  = strb.secStep && (calNow.second >= 6'd59);
    minStep  = secWrap;
    minWrap  = minStep && (calNow.minute >= 6'd59);
    hourStep = minWrap;
    hourWrap = hourStep && (calNow.hour >= 5'd23);
    dayStep  = hourWrap;
    dayWrap  = dayStep && (calNow.day >= dim);
    monStep  = dayWrap;
    monWrap  = monStep && (calNow.month >= 4'd12);
    yearStep = monWrap;
    yearWrap = yearStep && (calNow.year >= DATA_W'(99));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      calNow.second  <= '0;
      calNow.minute  <= '0;
      calNow.hour    <= '0;
      calNow.day     <= 5'd1;
      calNow.month   <= 4'd1;
      calNow.year    <= '0;
      calNow.century <= CENT_INIT;
    end else begin
      if (strb.wrField[ADR_SEC])       calNow.second <= strb.wrData[5:0];
      else if (strb.secStep)           calNow.second <= secWrap ? 6'd0 : calNow.second + 6'd1;

      if (strb.wrField[ADR_MIN])       calNow.minute <= strb.wrData[5:0];
      else if (minStep)                calNow.minute <= minWrap ? 6'd0 : calNow.minute + 6'd1;

      if (strb.wrField[ADR_HOUR])      calNow.hour <= strb.wrData[4:0];
      else if (hourStep)               calNow.hour <= hourWrap ? 5'd0 : calNow.hour + 5'd1;

      if (strb.wrField[ADR_DAY])       calNow.day <= strb.wrData[4:0];
      else if (dayStep)                calNow.day <= dayWrap ? 5'd1 : calNow.day + 5'd1;

      if (strb.wrField[ADR_MON])       calNow.month <= strb.wrData[3:0];
      else if (monStep)                calNow.month <= monWrap ? 4'd1 : calNow.month + 4'd1;

      if (strb.wrField[ADR_YEAR])      calNow.year <= strb.wrData;
      else if (yearStep)               calNow.year <= yearWrap ? '0 : calNow.year + 1'b1;

      if (strb.wrField[ADR_CENT])      calNow.century <= strb.wrData;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1024,
  parameter int RESET_CENTURY = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  calStrobe_t strb;
  calTime_t   calNow;
  logic       irqEn;
  logic       flag;

  rtc_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .strb(strb), .irqEn(irqEn), .flag(flag)
  );

  rtc_datapath #(.RESET_CENTURY(RESET_CENTURY)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .calNow(calNow)
  );

  always_comb begin
    case (addr)
      ADR_SEC:  rdData = DATA_W'(calNow.second);
      ADR_MIN:  rdData = DATA_W'(calNow.minute);
      ADR_HOUR: rdData = DATA_W'(calNow.hour);
      ADR_DAY:  rdData = DATA_W'(calNow.day);
      ADR_MON:  rdData = DATA_W'(calNow.month);
      ADR_YEAR: rdData = calNow.year;
      ADR_CENT: rdData = calNow.century;
      default:  rdData = {{(DATA_W-2){1'b0}}, flag, irqEn};
    endcase
  end

  assign irq = flag && irqEn;
endmodule

// File: rtl/rtc_checker.sv
`timescale 1ns/1ps
module rtc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [2:0] addr,
  input logic [7:0] wrData,
  input logic       irq,
  input logic       irqEn,
  input logic [5:0] secVal,
  input logic [4:0] dayVal,
  input logic [3:0] monVal,
  input logic [7:0] century
);
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> irqEn);

  p_sec_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    secVal < 6'd60);

  p_day_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dayVal >= 5'd1) && (dayVal <= 5'd31));

  p_month_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (monVal >= 4'd1) && (monVal <= 4'd12));

  p_century_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == 3'd6) |=> $stable(century));

  p_write_now_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd0 && wrData < 8'd60) |=> (8'(secVal) == $past(wrData)));
endmodule

bind rtc_calendar rtc_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .irq(irq), .irqEn(irqEn), .secVal(calNow.second), .dayVal(calNow.day),
  .monVal(calNow.month), .century(calNow.century)
);

// File: tb/test_rtc_calendar.sv
`timescale 1ns/1ps
module test_rtc_calendar;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_calendar i_rtc_calendar (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // start sec,min,hour,day,mon,year -> expected sec,min,hour,day,mon,year
  localparam int NV = 8;
  localparam int VEC [0:NV-1][0:11] = '{
    '{30, 10,  5, 15,  6, 21,   31, 10,  5, 15, 6, 21},
    '{59, 59, 10,  3,  3, 22,    0,  0, 11,  3, 3, 22},
    '{59, 59, 23, 30,  4, 22,    0,  0,  0,  1, 5, 22},
    '{59, 59, 23, 28,  2,  4,    0,  0,  0, 29, 2,  4},
    '{59, 59, 23, 28,  2,  3,    0,  0,  0,  1, 3,  3},
    '{59, 59, 23, 31, 12, 99,    0,  0,  0,  1, 1,  0},
    '{59, 59, 23, 31,  1, 50,    0,  0,  0,  1, 2, 50},
    '{59, 59, 23, 29,  2,  8,    0,  0,  0,  1, 3,  8}
  };
  localparam string VTAG [0:NV-1] = '{"R2", "R3", "R4", "R5", "R5", "R6", "R4", "R5"};

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input int a, input int d);
    addr = 3'(a); wrData = 8'(d); wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic readReg(input int a, output int v);
    addr = 3'(a); rdEn = 1'b1;
    #1 v = int'(rdData);
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  initial begin
    #750000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    readReg(0, v); check("R1 second", v, 0);
    readReg(1, v); check("R1 minute", v, 0);
    readReg(2, v); check("R1 hour", v, 0);
    readReg(3, v); check("R1 day", v, 1);
    readReg(4, v); check("R1 month", v, 1);
    readReg(5, v); check("R1 year", v, 0);
    readReg(6, v); check("R1 century", v, 19);
    readReg(7, v); check("R1 status", v, 0);
    check("R1 irq", int'(irq), 0);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      writeReg(5, VEC[i][5]);
      writeReg(4, VEC[i][4]);
      writeReg(3, VEC[i][3]);
      writeReg(2, VEC[i][2]);
      writeReg(1, VEC[i][1]);
      writeReg(0, VEC[i][0]);   // R8 restarts prescaler
      readReg(0, v); check("R8 write visible", v, VEC[i][0]);
      ticks(1023);
      readReg(0, v); check("R2 no step at 1023", v, VEC[i][0]);
      ticks(1);
      for (int f = 0; f < 6; f++) begin
        readReg(f, v); check(VTAG[i], v, VEC[i][6 + f]);
      end
      if (i == 5) begin
        readReg(6, v); check("R7 century kept over year wrap", v, 19);
      end
    end

    // R7 century write
    writeReg(6, 20);
    readReg(6, v); check("R7 century write", v, 20);

    // R8 seconds write mid-count restarts prescaler
    writeReg(0, 10);
    ticks(600);
    writeReg(0, 20);
    ticks(1023);
    readReg(0, v); check("R8 prescaler restart", v, 20);
    ticks(1);
    readReg(0, v); check("R8 after restart", v, 21);

    // R9 disabled ticks set nothing
    ticks(5);
    check("R9 irq disabled", int'(irq), 0);
    readReg(7, v); check("R9 flag stays clear", v, 0);

    // R9 enable then tick
    writeReg(7, 1);
    check("R9 irq before tick", int'(irq), 0);
    ticks(1);
    check("R9 irq after tick", int'(irq), 1);

    // R10 read clears flag
    readReg(7, v); check("R10 status", v, 3);
    check("R10 irq cleared", int'(irq), 0);
    readReg(7, v); check("R10 flag cleared", v, 1);

    // R10 read and tick in the same cycle: flag stays set
    ticks(1);
    addr = 3'd7; rdEn = 1'b1; tick = 1'b1;
    @(posedge clk); #1;
    rdEn = 1'b0; tick = 1'b0;
    check("R10 set wins", int'(irq), 1);

    // R9 disabling gates irq while flag held
    writeReg(7, 0);
    check("R9 irq gated", int'(irq), 0);
    readReg(7, v); check("R9 flag held", v, 2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule